// File: doc/BRIEF.md
# RV32I Program Counter and Branch Unit

This block owns the program counter of a 32-bit RISC-V core and decides, once per clock, which address comes next. Each cycle the decoder presents the class of the current instruction, its funct3 field, the two source register values and the raw instruction word. The unit rebuilds the branch, jump and register-jump immediates from their scattered instruction bits. It evaluates all six branch conditions and loads the register with either the fall-through address or the transfer target.

The unit keeps a two-state flow record. ST_FLOW means the last update was the fall-through step. ST_REDIR means the last update was a taken transfer. The transition to ST_REDIR happens on a taken branch, a JAL or a JALR. The transition to ST_FLOW happens on a sequential instruction, a branch whose condition fails, or an illegal branch code. Reset forces ST_FLOW. The taken output is decoded from this state. Two more registered flags, for a misaligned target and an illegal branch code, are loaded in the same edge.

Top module: `pc_branch_unit`

## Requirements
- R1: A clock edge with `rst` high loads `pc_o` with START_ADDR and clears `taken_o`, `misalign_o` and `illegal_o`.
- R2: With class code 00 (sequential) the PC advances by 4 at the edge and `taken_o` is 0 afterwards.
- R3: With class code 01 (branch), funct3 000 is taken when the operands are equal, and funct3 001 is taken when they differ.
- R4: With class 01, funct3 100 is taken when rs1 < rs2 as signed numbers, and funct3 101 is taken when rs1 >= rs2 signed.
- R5: With class 01, funct3 110 is taken when rs1 < rs2 as unsigned numbers, and funct3 111 is taken when rs1 >= rs2 unsigned.
- R6: A taken branch loads PC + offset. The offset is sign-extended from bit 12, with bit 12 = instr[31], bit 11 = instr[7], bits 10:5 = instr[30:25], bits 4:1 = instr[11:8] and bit 0 = 0. A branch that is not taken advances the PC by 4.
- R7: Class code 10 (JAL) is always taken and loads PC + offset. The offset is sign-extended from bit 20, with bit 20 = instr[31], bits 19:12 = instr[19:12], bit 11 = instr[20], bits 10:1 = instr[30:21] and bit 0 = 0.
- R8: Class code 11 (JALR) is always taken and loads rs1 plus the sign-extended instr[31:20], with bit 0 of the sum cleared.
- R9: `link_o` always equals `pc_o` + 4, combinationally, for the instruction being presented.
- R10: With class 01, funct3 010 and 011 are not taken, the PC advances by 4, and `illegal_o` is 1 after that edge.
- R11: A taken transfer whose target has bit 1 set still loads the PC, and `misalign_o` is 1 after that edge. A transfer that is not taken never raises `misalign_o`.
- R12: `taken_o`, `misalign_o` and `illegal_o` describe the instruction presented before the last edge, and they change in the same edge as `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 2 | Instruction class: 00 sequential, 01 branch, 10 JAL, 11 JALR |
| funct3_i | input | 3 | Branch condition code |
| rs1_val_i | input | XLEN | First source operand |
| rs2_val_i | input | XLEN | Second source operand |
| instr_i | input | 32 | Raw instruction word |
| pc_o | output | XLEN | Current program counter |
| taken_o | output | 1 | Last update was a taken transfer |
| link_o | output | XLEN | Return address for rd (PC + 4) |
| misalign_o | output | 1 | Last taken target had bit 1 set |
| illegal_o | output | 1 | Last branch used an undefined condition code |

## Verification
`link_o` is combinational, so the bench checks it shortly after it drives the inputs, within the same cycle. The next PC and the three flags each pass through one register. They are therefore checked one full cycle after the stimulus, at the following falling edge, against a model PC that the bench advances itself. Reset is likewise checked at the falling edge that follows a rising edge with `rst` high.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;

    typedef enum logic [1:0] {
        XK_SEQ    = 2'b00,
        XK_BRANCH = 2'b01,
        XK_JAL    = 2'b10,
        XK_JALR   = 2'b11
    } xfer_kind_e;

    typedef enum logic [2:0] {
        BC_EQ  = 3'b000,
        BC_NE  = 3'b001,
        BC_LT  = 3'b100,
        BC_GE  = 3'b101,
        BC_LTU = 3'b110,
        BC_GEU = 3'b111
    } br_cond_e;

    typedef enum logic {
        ST_FLOW,
        ST_REDIR
    } flow_state_e;

endpackage

// File: rtl/pcbu_imm_gen.sv
module pcbu_imm_gen #(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] b_imm,
    output logic [XLEN-1:0] j_imm,
    output logic [XLEN-1:0] i_imm
);
    localparam int B_EXT = XLEN - 13;
    localparam int J_EXT = XLEN - 21;
    localparam int I_EXT = XLEN - 12;

    always_comb begin
        b_imm = {{B_EXT{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        j_imm = {{J_EXT{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
        i_imm = {{I_EXT{instr[31]}}, instr[31:20]};
    end
endmodule

// File: rtl/pcbu_branch_cmp.sv
module pcbu_branch_cmp
    import pcbu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [2:0]      cond,
    output logic            cond_true,
    output logic            bad_code
);
    localparam int MSB = XLEN - 1;

    logic lt_s;
    logic lt_u;
    logic eq;

    assign eq = (op_a == op_b);

    generate
        if (SHARED_SUB) begin : g_shared
            logic [XLEN:0] diff;
            assign diff = {1'b0, op_a} - {1'b0, op_b};
            assign lt_u = diff[XLEN];
            assign lt_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : diff[XLEN];
        end else begin : g_split
            assign lt_u = (op_a < op_b);
            assign lt_s = ($signed(op_a) < $signed(op_b));
        end
    endgenerate

    always_comb begin
        cond_true = 1'b0;
        bad_code  = 1'b0;
        unique case (cond)
            BC_EQ:   cond_true = eq;
            BC_NE:   cond_true = !eq;
            BC_LT:   cond_true = lt_s;
            BC_GE:   cond_true = !lt_s;
            BC_LTU:  cond_true = lt_u;
            BC_GEU:  cond_true = !lt_u;
            default: bad_code  = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcbu_target_sel.sv
module pcbu_target_sel
    import pcbu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_kind_e      kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] b_imm,
    input  logic [XLEN-1:0] j_imm,
    input  logic [XLEN-1:0] i_imm,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] reg_sum;

    assign reg_sum = rs1 + i_imm;

    always_comb begin
        unique case (kind)
            XK_JAL:  target = pc + j_imm;
            XK_JALR: target = {reg_sum[XLEN-1:1], 1'b0};
            default: target = pc + b_imm;
        endcase
    end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
    import pcbu_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] START_ADDR = 'h0000_0100,
    parameter bit              SHARED_SUB = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cls_i,
    input  logic [2:0]      funct3_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] pc_o,
    output logic            taken_o,
    output logic [XLEN-1:0] link_o,
    output logic            misalign_o,
    output logic            illegal_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    xfer_kind_e      kind;
    flow_state_e     st_q;
    flow_state_e     st_d;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic            mis_q;
    logic            ill_q;
    logic [XLEN-1:0] b_imm;
    logic [XLEN-1:0] j_imm;
    logic [XLEN-1:0] i_imm;
    logic [XLEN-1:0] target;
    logic            cond_true;
    logic            bad_code;
    logic            redirect;
    logic            ill_now;

    assign kind = xfer_kind_e'(cls_i);

    pcbu_imm_gen #(.XLEN(XLEN)) u_imm (
        .instr (instr_i),
        .b_imm (b_imm),
        .j_imm (j_imm),
        .i_imm (i_imm)
    );

    pcbu_branch_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
        .op_a      (rs1_val_i),
        .op_b      (rs2_val_i),
        .cond      (funct3_i),
        .cond_true (cond_true),
        .bad_code  (bad_code)
    );

    pcbu_target_sel #(.XLEN(XLEN)) u_tgt (
        .kind   (kind),
        .pc     (pc_q),
        .rs1    (rs1_val_i),
        .b_imm  (b_imm),
        .j_imm  (j_imm),
        .i_imm  (i_imm),
        .target (target)
    );

    // Next-state decision
    always_comb begin
        redirect = 1'b0;
        ill_now  = 1'b0;
        unique case (kind)
            XK_SEQ:    redirect = 1'b0;
            XK_BRANCH: begin
                ill_now  = bad_code;
                redirect = cond_true && !bad_code;
            end
            XK_JAL:    redirect = 1'b1;
            XK_JALR:   redirect = 1'b1;
            default:   redirect = 1'b0;
        endcase
        st_d = redirect ? ST_REDIR : ST_FLOW;
        pc_d = redirect ? target : (pc_q + STEP);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FLOW;
            pc_q  <= START_ADDR;
            mis_q <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pc_q  <= pc_d;
            mis_q <= redirect && target[1];
            ill_q <= ill_now;
        end
    end

    // Outputs
    always_comb begin
        pc_o       = pc_q;
        link_o     = pc_q + STEP;
        taken_o    = (st_q == ST_REDIR);
        misalign_o = mis_q;
        illegal_o  = ill_q;
    end
endmodule

// File: rtl/pcbu_checker.sv
module pcbu_checker #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] START_ADDR = 'h0000_0100
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      cls_i,
    input logic [2:0]      funct3_i,
    input logic [XLEN-1:0] rs1_val_i,
    input logic [XLEN-1:0] rs2_val_i,
    input logic [XLEN-1:0] pc_o,
    input logic            taken_o,
    input logic            misalign_o,
    input logic            illegal_o
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_o == START_ADDR && !taken_o && !misalign_o && !illegal_o));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b00) |=> (pc_o == $past(pc_o) + XLEN'(4) && !taken_o));

    p_beq_equal_r3: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b01 && funct3_i == 3'b000 && rs1_val_i == rs2_val_i) |=> taken_o);

    p_bne_equal_r3: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b01 && funct3_i == 3'b001 && rs1_val_i == rs2_val_i) |=> !taken_o);

    p_jal_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b10) |=> taken_o);

    p_jalr_even_r8: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b11) |=> (taken_o && !pc_o[0]));

    p_illegal_code_r10: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 2'b01 && funct3_i[2:1] == 2'b01) |=>
            (illegal_o && !taken_o && pc_o == $past(pc_o) + XLEN'(4)));

    p_misalign_r11: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (taken_o && pc_o[1]));
endmodule

bind pc_branch_unit pcbu_checker #(.XLEN(XLEN), .START_ADDR(START_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cls_i      (cls_i),
    .funct3_i   (funct3_i),
    .rs1_val_i  (rs1_val_i),
    .rs2_val_i  (rs2_val_i),
    .pc_o       (pc_o),
    .taken_o    (taken_o),
    .misalign_o (misalign_o),
    .illegal_o  (illegal_o)
);

// File: tb/pc_branch_unit_test.sv
`timescale 1ns/1ps
module pc_branch_unit_test;
    localparam logic [31:0] BOOT   = 32'h0000_1000;
    localparam int          TCLK   = 20;
    localparam int          NRAND  = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cls_i = 2'b00;
    logic [2:0]  funct3_i = 3'b000;
    logic [31:0] rs1_val_i = '0;
    logic [31:0] rs2_val_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_o;
    logic        taken_o;
    logic [31:0] link_o;
    logic        misalign_o;
    logic        illegal_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] exp_pc;

    always #(TCLK/2) clk = ~clk;

    pc_branch_unit #(.XLEN(32), .START_ADDR(BOOT)) uut (
        .clk(clk), .rst(rst), .cls_i(cls_i), .funct3_i(funct3_i),
        .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .instr_i(instr_i),
        .pc_o(pc_o), .taken_o(taken_o), .link_o(link_o),
        .misalign_o(misalign_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] imm_b(input logic [31:0] w);
        return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction
    function automatic logic [31:0] imm_j(input logic [31:0] w);
        return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction
    function automatic logic [31:0] imm_i(input logic [31:0] w);
        return {{20{w[31]}}, w[31:20]};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] off);
        return {off[12], off[10:5], 5'd0, 5'd0, 3'b000, off[4:1], off[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] imm);
        return {imm, 5'd1, 3'b000, 5'd1, 7'b1100111};
    endfunction
    // 0 = not taken, 1 = taken, 2 = undefined code
    function automatic int cond_eval(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            3'b000: return int'(a == b);
            3'b001: return int'(a != b);
            3'b100: return int'($signed(a) < $signed(b));
            3'b101: return int'($signed(a) >= $signed(b));
            3'b110: return int'(a < b);
            3'b111: return int'(a >= b);
            default: return 2;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [2:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] w, input string tag);
        logic [31:0] tgt;
        logic [31:0] npc;
        logic        red;
        logic        ill;
        logic [31:0] sum;
        int          c;
        cls_i = k; funct3_i = f; rs1_val_i = a; rs2_val_i = b; instr_i = w;
        #1;
        chk("R9 link", link_o, exp_pc + 32'd4);
        red = 1'b0; ill = 1'b0; tgt = '0;
        case (k)
            2'b01: begin
                c = cond_eval(f, a, b);
                ill = (c == 2);
                red = (c == 1);
                tgt = exp_pc + imm_b(w);
            end
            2'b10: begin red = 1'b1; tgt = exp_pc + imm_j(w); end
            2'b11: begin
                red = 1'b1;
                sum = a + imm_i(w);
                tgt = {sum[31:1], 1'b0};
            end
            default: red = 1'b0;
        endcase
        npc = red ? tgt : exp_pc + 32'd4;
        @(negedge clk);
        chk({tag, " pc"}, pc_o, npc);
        chk({tag, " R12 flags"}, {29'd0, taken_o, misalign_o, illegal_o},
            {29'd0, red, red & tgt[1], ill});
        exp_pc = npc;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc", pc_o, BOOT);
        chk("R1 flags", {29'd0, taken_o, misalign_o, illegal_o}, 32'd0);
        rst = 1'b0;
        exp_pc = BOOT;
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0]  k;
        logic [2:0]  f;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] w;
        string       tag;
        void'($urandom(32'h5eed));
        @(negedge clk);
        do_reset();

        step(2'b00, 3'b000, 0, 0, 32'h0000_0013, "R2 seq");
        step(2'b01, 3'b000, 32'd7, 32'd7, enc_b(13'd16), "R3 R6 beq eq");
        step(2'b01, 3'b001, 32'd7, 32'd7, enc_b(13'd16), "R3 bne eq");
        step(2'b01, 3'b001, 32'd7, 32'd8, enc_b(13'd8), "R3 bne ne");
        step(2'b01, 3'b100, 32'hFFFF_FFFF, 32'd1, enc_b(-13'sd8), "R4 R6 blt neg");
        step(2'b01, 3'b110, 32'hFFFF_FFFF, 32'd1, enc_b(13'd64), "R5 bltu");
        step(2'b01, 3'b111, 32'hFFFF_FFFF, 32'd1, enc_b(13'd32), "R5 bgeu");
        step(2'b01, 3'b101, 32'd5, 32'd5, enc_b(-13'sd4096), "R4 R6 bge eq");
        step(2'b01, 3'b101, 32'h8000_0000, 32'd0, enc_b(13'd12), "R4 bge min");
        step(2'b10, 3'b000, 0, 0, enc_j(21'h800), "R7 jal fwd");
        step(2'b10, 3'b000, 0, 0, enc_j(-21'sd4096), "R7 jal back");
        step(2'b11, 3'b000, 32'h0000_2001, 0, enc_i(12'h010), "R8 jalr odd");
        step(2'b11, 3'b000, 32'h0000_3000, 0, enc_i(12'hFFC), "R8 jalr neg");
        step(2'b01, 3'b010, 32'd1, 32'd1, enc_b(13'd16), "R10 code 010");
        step(2'b01, 3'b011, 32'd1, 32'd2, enc_b(13'd16), "R10 code 011");
        step(2'b01, 3'b000, 32'd3, 32'd3, enc_b(13'd6), "R11 misalign br");
        step(2'b00, 3'b000, 0, 0, 32'h0, "R2 after misalign");
        step(2'b01, 3'b000, 32'd3, 32'd4, enc_b(13'd6), "R11 not taken");
        step(2'b11, 3'b000, 32'h0000_4000, 0, enc_i(12'h002), "R11 R8 jalr mis");
        step(2'b11, 3'b000, 32'h0000_5000, 0, enc_i(12'h000), "R8 realign");

        for (int i = 0; i < NRAND; i++) begin
            k = 2'($urandom % 4);
            f = 3'($urandom % 8);
            a = $urandom;
            b = ($urandom % 4 == 0) ? a : $urandom;
            if ($urandom % 3 == 0) b = a ^ 32'h8000_0000;
            w = $urandom;
            case (k)
                2'b00: tag = "R2 rnd";
                2'b10: tag = "R7 rnd";
                2'b11: tag = "R8 rnd";
                default: begin
                    if (f[2:1] == 2'b01)      tag = "R10 rnd";
                    else if (f[2:1] == 2'b00) tag = "R3 R6 rnd";
                    else if (f[2:1] == 2'b10) tag = "R4 R6 rnd";
                    else                      tag = "R5 R6 rnd";
                end
            endcase
            step(k, f, a, b, w, {tag, " R11"});
        end

        step(2'b10, 3'b000, 0, 0, enc_j(21'h100), "R7 before reset");
        do_reset();
        step(2'b00, 3'b000, 0, 0, 32'h0, "R2 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule